// File: doc/BRIEF.md
# Dual-Sided Mailbox Messaging Unit

This block passes 32-bit words between two processors that sit on the same clock. Each processor has its own port, called side A and side B here. Each port is a simple word-addressed register bus with a write strobe, a read strobe, an address, write data and registered read data. On each side there are four send slots, four receive slots, a status word and a control word. A word written into send slot n on one side lands in receive slot n on the other side. That slot then counts as occupied until the far side reads it.

The status word shows two things. For each send slot it shows whether the slot is free. For each receive slot it shows whether the slot holds unread data. The free flags sit in descending positions below bit 23 and the occupied flags in descending positions below bit 27. The status word also shows the 3-bit flag field that the other side last wrote into its control word.

The control word holds three sets of four interrupt enables: general, receive and send. It also holds four general request bits and the 3-bit flag field. Each side has one registered interrupt output. A general request raised on one side is enabled by the general-enable bit at the same channel position on the other side.

Top module: `mbox_pair`

## Requirements
- R1: After reset, each side's status word reads 0x00F00000 (all send slots free, no receive slot occupied, flag field zero), its control word reads 0, and both interrupt outputs are low.
- R2: Writing send slot n (word address n, 0..3) on one side clears that side's free flag at status bit 23-n. At the same clock edge it sets the other side's occupied flag at status bit 27-n. The other side then reads the written word at word address 4+n.
- R3: Reading receive slot n (address 4+n) returns its word on rdata in the cycle after the read strobe. The read clears the reader's occupied flag at bit 27-n and sets the sender's free flag at bit 23-n again.
- R4: The four slots in each direction, and the two directions, operate independently. Flags only change for the slot and direction that was accessed.
- R5: Writing a send slot that is already occupied replaces the stored word, and the slot stays occupied. Reading an empty receive slot returns the last stored word and changes no flag.
- R6: The control word is at address 9. Only bits 31:16 and 2:0 can be written, and every other bit reads 0. Writes to the status word (address 8) have no effect.
- R7: The flag field written into bits 2:0 of one side's control word reads back in bits 2:0 of the other side's status word.
- R8: A side's interrupt rises one cycle after its receive slot n is occupied while receive enable bit 27-n of its control word is set. It falls one cycle after the slot is read.
- R9: A side's interrupt is raised one cycle after its send slot n is free while send enable bit 23-n is set. It drops one cycle after the slot is written.
- R10: A general request bit 19-n written on one side raises the other side's interrupt when that side's general enable bit 31-n is set. The requesting side's own interrupt is not raised by it.
- R11: One cycle after a side writes 0 to its control word, every enable and request of that side is off, and that side's interrupt is low unless the other side's own enables call for it.
- R12: When a send slot is written in the same cycle as the matching receive slot is read, the read returns the old word. The write wins: the slot stays occupied and holds the new word.
- R13: Reads of unmapped word addresses (10 to 15) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid the cycle after a_rd |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid the cycle after b_rd |
| b_irq | output | 1 | Side B interrupt |

## Verification
The main message path is tried with three patterns. A single word on slot 0 shows that the flags move together on both sides. Several slots loaded in both directions at once show that the bit positions are not shared, because each status word is compared as a whole and the descending layout has to be right. A write and a read colliding on one slot shows that write wins over read, and a double write shows the overwrite rule. Each interrupt source is enabled alone, so a raised interrupt points at exactly one of the receive, send or cross-side general paths.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int SLOT_MAX  = 4;
  localparam int RX_BASE   = 4;
  localparam int STAT_ADDR = 8;
  localparam int CTRL_ADDR = 9;
  localparam int FREE0_BIT = 23;
  localparam int OCC0_BIT  = 27;
  localparam int GEN_EN_HI = 31;
  localparam int RX_EN_HI  = 27;
  localparam int TX_EN_HI  = 23;
  localparam int GREQ_HI   = 19;
  localparam int FLG_W     = 3;
  localparam logic [31:0] CTRL_WMASK = 32'hFFFF_0007;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] word_q,
  output logic              occ_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      occ_q  <= 1'b0;
    end else if (push) begin
      word_q <= push_data;
      occ_q  <= 1'b1;
    end else if (pop) begin
      occ_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic                       rd,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NCH-1:0]             tx_occ,
  input  logic [NCH-1:0]             rx_occ,
  input  logic [NCH-1:0][DATA_W-1:0] rx_word,
  input  logic [FLG_W-1:0]           peer_flg,
  input  logic [3:0]                 peer_greq,
  output logic [NCH-1:0]             tx_push,
  output logic [NCH-1:0]             rx_pop,
  output logic [31:0]                ctrl_q,
  output logic [DATA_W-1:0]          rdata,
  output logic                       irq
);
  logic [31:0] stat;
  logic [3:0]  free_v, occ_v;
  logic [DATA_W-1:0] rd_mux;
  logic irq_d;

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      tx_push[n] = wr && (addr == ADDR_W'(n));
      rx_pop[n]  = rd && (addr == ADDR_W'(RX_BASE + n));
    end
  end

  always_comb begin
    stat = '0;
    for (int n = 0; n < NCH; n++) begin
      stat[FREE0_BIT - n] = ~tx_occ[n];
      stat[OCC0_BIT - n]  = rx_occ[n];
    end
    stat[FLG_W-1:0] = peer_flg;
    free_v = stat[FREE0_BIT -: 4];
    occ_v  = stat[OCC0_BIT -: 4];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(STAT_ADDR)) rd_mux = DATA_W'(stat);
    else if (addr == ADDR_W'(CTRL_ADDR)) rd_mux = DATA_W'(ctrl_q);
    else begin
      for (int n = 0; n < NCH; n++)
        if (addr == ADDR_W'(RX_BASE + n)) rd_mux = rx_word[n];
    end
  end

  assign irq_d = |(ctrl_q[GEN_EN_HI -: 4] & peer_greq)
               | |(ctrl_q[RX_EN_HI -: 4] & occ_v)
               | |(ctrl_q[TX_EN_HI -: 4] & free_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr && addr == ADDR_W'(CTRL_ADDR))
        ctrl_q <= wdata[31:0] & CTRL_WMASK;
      if (rd) rdata <= rd_mux;
      irq <= irq_d;
    end
  end
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  logic [NCH-1:0] ab_occ, ba_occ;
  logic [NCH-1:0] a_push, a_pop, b_push, b_pop;
  logic [NCH-1:0][DATA_W-1:0] ab_word, ba_word;
  logic [31:0] a_ctrl, b_ctrl;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    mbox_slot #(.DATA_W(DATA_W)) u_ab (
      .clk(clk), .rst(rst), .push(a_push[g]), .push_data(a_wdata),
      .pop(b_pop[g]), .word_q(ab_word[g]), .occ_q(ab_occ[g]));
    mbox_slot #(.DATA_W(DATA_W)) u_ba (
      .clk(clk), .rst(rst), .push(b_push[g]), .push_data(b_wdata),
      .pop(a_pop[g]), .word_q(ba_word[g]), .occ_q(ba_occ[g]));
  end

  mbox_port #(.DATA_W(DATA_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_pa (
    .clk(clk), .rst(rst), .wr(a_wr), .rd(a_rd), .addr(a_addr), .wdata(a_wdata),
    .tx_occ(ab_occ), .rx_occ(ba_occ), .rx_word(ba_word),
    .peer_flg(b_ctrl[FLG_W-1:0]), .peer_greq(b_ctrl[GREQ_HI -: 4]),
    .tx_push(a_push), .rx_pop(a_pop), .ctrl_q(a_ctrl),
    .rdata(a_rdata), .irq(a_irq));

  mbox_port #(.DATA_W(DATA_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_pb (
    .clk(clk), .rst(rst), .wr(b_wr), .rd(b_rd), .addr(b_addr), .wdata(b_wdata),
    .tx_occ(ba_occ), .rx_occ(ab_occ), .rx_word(ab_word),
    .peer_flg(a_ctrl[FLG_W-1:0]), .peer_greq(a_ctrl[GREQ_HI -: 4]),
    .tx_push(b_push), .rx_pop(b_pop), .ctrl_q(b_ctrl),
    .rdata(b_rdata), .irq(b_irq));
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk
  import mbox_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              a_wr,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_rd,
  input logic [ADDR_W-1:0] b_addr,
  input logic [NCH-1:0]    ab_occ,
  input logic [31:0]       a_ctrl,
  input logic [31:0]       b_ctrl,
  input logic              a_irq,
  input logic              b_irq
);
  logic [3:0] b_occ_v;
  always_comb begin
    b_occ_v = '0;
    for (int n = 0; n < NCH; n++) b_occ_v[3-n] = ab_occ[n];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r2_push_sets: assert property (@(posedge clk) disable iff (rst)
      (a_wr && a_addr == ADDR_W'(g)) |=> ab_occ[g]);
    a_r3_pop_clears: assert property (@(posedge clk) disable iff (rst)
      (b_rd && b_addr == ADDR_W'(RX_BASE + g) && !(a_wr && a_addr == ADDR_W'(g)))
      |=> !ab_occ[g]);
    a_r4_untouched_holds: assert property (@(posedge clk) disable iff (rst)
      (!(a_wr && a_addr == ADDR_W'(g)) && !(b_rd && b_addr == ADDR_W'(RX_BASE + g)))
      |=> $stable(ab_occ[g]));
  end

  a_r8_rx_irq: assert property (@(posedge clk) disable iff (rst)
    (|(b_ctrl[RX_EN_HI -: 4] & b_occ_v)) |=> b_irq);
  a_r11_a_quiet: assert property (@(posedge clk) disable iff (rst)
    (a_ctrl[31:20] == 12'h0 && b_ctrl[GREQ_HI -: 4] == 4'h0) |=> !a_irq);
  a_r11_b_quiet: assert property (@(posedge clk) disable iff (rst)
    (b_ctrl[31:20] == 12'h0 && a_ctrl[GREQ_HI -: 4] == 4'h0) |=> !b_irq);
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    a_ctrl[15:FLG_W] == '0 && b_ctrl[15:FLG_W] == '0);
endmodule

bind mbox_pair mbox_pair_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .a_wr(a_wr), .a_addr(a_addr), .b_rd(b_rd),
  .b_addr(b_addr), .ab_occ(ab_occ), .a_ctrl(a_ctrl), .b_ctrl(b_ctrl),
  .a_irq(a_irq), .b_irq(b_irq));

// File: tb/sim_mbox_pair.sv
`timescale 1ns/1ps
module sim_mbox_pair;
  logic clk = 1'b0, rst = 1'b1;
  logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [3:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;
  int n_run = 0, n_fail = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  mbox_pair u0 (.clk(clk), .rst(rst),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(bit side, logic [3:0] ad, logic [31:0] d);
    @(negedge clk);
    if (side) begin b_wr = 1; b_addr = ad; b_wdata = d; end
    else      begin a_wr = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic rd(bit side, logic [3:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (side) begin b_rd = 1; b_addr = ad; end
    else      begin a_rd = 1; a_addr = ad; end
    @(negedge clk);
    a_rd = 0; b_rd = 0;
    d = side ? b_rdata : a_rdata;
  endtask

  task automatic t_reset();
    chk("R1 a_irq", {31'd0, a_irq}, 0);
    chk("R1 b_irq", {31'd0, b_irq}, 0);
    rd(0, 8, v); chk("R1 A status", v, 32'h00F0_0000);
    rd(1, 8, v); chk("R1 B status", v, 32'h00F0_0000);
    rd(0, 9, v); chk("R1 A ctrl", v, 0);
    rd(1, 9, v); chk("R1 B ctrl", v, 0);
  endtask

  task automatic t_basic();
    wr(0, 0, 32'hCAFE_0001);
    rd(0, 8, v); chk("R2 A free0 clear", v, 32'h0070_0000);
    rd(1, 8, v); chk("R2 B occ0 set", v, 32'h08F0_0000);
    rd(1, 4, v); chk("R3 B rx0 data", v, 32'hCAFE_0001);
    rd(1, 8, v); chk("R3 B occ0 clear", v, 32'h00F0_0000);
    rd(0, 8, v); chk("R3 A free0 back", v, 32'h00F0_0000);
  endtask

  task automatic t_multi();
    wr(0, 1, 32'h1111_0001);
    wr(0, 3, 32'h3333_0003);
    wr(1, 2, 32'h2222_0002);
    rd(0, 8, v); chk("R4 A status", v, 32'h02A0_0000);
    rd(1, 8, v); chk("R4 B status", v, 32'h05D0_0000);
    rd(1, 7, v); chk("R4 B rx3", v, 32'h3333_0003);
    rd(1, 5, v); chk("R4 B rx1", v, 32'h1111_0001);
    rd(0, 6, v); chk("R4 A rx2", v, 32'h2222_0002);
    rd(0, 8, v); chk("R4 A drained", v, 32'h00F0_0000);
    rd(1, 8, v); chk("R4 B drained", v, 32'h00F0_0000);
  endtask

  task automatic t_overwrite();
    wr(0, 2, 32'hAAAA_0000);
    wr(0, 2, 32'hBBBB_0000);
    rd(1, 8, v); chk("R5 still occupied", v, 32'h02F0_0000);
    rd(1, 6, v); chk("R5 newest word", v, 32'hBBBB_0000);
    rd(1, 6, v); chk("R5 empty read word", v, 32'hBBBB_0000);
    rd(1, 8, v); chk("R5 empty read no flag", v, 32'h00F0_0000);
  endtask

  task automatic t_ctrl();
    wr(0, 9, 32'hFFFF_FFFF);
    rd(0, 9, v); chk("R6 ctrl mask", v, 32'hFFFF_0007);
    wr(0, 9, 32'h0);
    wr(1, 8, 32'hFFFF_FFFF);
    rd(1, 8, v); chk("R6 status write ignored", v, 32'h00F0_0000);
    rd(0, 12, v); chk("R13 unmapped 12", v, 0);
    rd(1, 15, v); chk("R13 unmapped 15", v, 0);
  endtask

  task automatic t_flags();
    wr(0, 9, 32'h5);
    rd(1, 8, v); chk("R7 A flags at B", v, 32'h00F0_0005);
    rd(0, 8, v); chk("R7 A own status", v, 32'h00F0_0000);
    wr(0, 9, 32'h0);
  endtask

  task automatic t_irq_rx();
    wr(1, 9, 32'h0400_0000);
    tick(); chk("R8 idle low", {31'd0, b_irq}, 0);
    wr(0, 0, 32'h1);
    tick(); chk("R8 other slot no irq", {31'd0, b_irq}, 0);
    wr(0, 1, 32'h2);
    chk("R8 irq lags a cycle", {31'd0, b_irq}, 0);
    tick(); chk("R8 irq raised", {31'd0, b_irq}, 1);
    rd(1, 5, v);
    tick(); chk("R8 irq dropped", {31'd0, b_irq}, 0);
    rd(1, 4, v);
    wr(1, 9, 32'h0);
  endtask

  task automatic t_irq_tx();
    wr(0, 9, 32'h0010_0000);
    tick(); chk("R9 free irq", {31'd0, a_irq}, 1);
    wr(0, 3, 32'h33);
    tick(); chk("R9 occupied low", {31'd0, a_irq}, 0);
    rd(1, 7, v);
    tick(); chk("R9 free again", {31'd0, a_irq}, 1);
    wr(0, 9, 32'h0);
    tick(); chk("R11 A cleared", {31'd0, a_irq}, 0);
  endtask

  task automatic t_greq();
    wr(1, 9, 32'h8000_0000);
    wr(0, 9, 32'h0008_0000);
    tick(); chk("R10 B irq", {31'd0, b_irq}, 1);
    chk("R10 A no irq", {31'd0, a_irq}, 0);
    wr(0, 9, 32'h0004_0000);
    tick(); chk("R10 unmatched bit", {31'd0, b_irq}, 0);
    wr(0, 9, 32'h0008_0000);
    wr(1, 9, 32'h0);
    tick(); chk("R11 B cleared", {31'd0, b_irq}, 0);
    wr(0, 9, 32'h0);
  endtask

  task automatic t_same();
    wr(0, 0, 32'h0000_00AA);
    @(negedge clk);
    a_wr = 1; a_addr = 0; a_wdata = 32'h0000_00BB;
    b_rd = 1; b_addr = 4;
    @(negedge clk);
    a_wr = 0; b_rd = 0;
    chk("R12 read old word", b_rdata, 32'h0000_00AA);
    rd(1, 8, v); chk("R12 stays occupied", v, 32'h08F0_0000);
    rd(1, 4, v); chk("R12 new word", v, 32'h0000_00BB);
  endtask

  initial begin
    #(5.0 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_multi();
    t_overwrite();
    t_ctrl();
    t_flags();
    t_irq_rx();
    t_irq_tx();
    t_greq();
    t_same();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule